// File: doc/BRIEF.md
# Composite Sync Separator and Burst Gate

This block watches a negative-going composite sync line that is synchronous to a clock at four times the colour subcarrier frequency (about 14.318 MHz for NTSC, about 17.734 MHz for PAL). It counts how many clock edges each low pulse lasts and decides what kind of pulse it was once the pulse ends. A pulse counts as a line (horizontal) sync only when its trailing edge falls inside an acceptance window. A pulse longer than twice the window's upper bound counts as a vertical broad pulse. Every other pulse, whether too short or too long for the window, counts as an equalizing or serration pulse.

A qualified line sync gives a one-cycle strobe at its trailing edge. It also arms a burst gate that opens at a fixed clock offset from the sync leading edge and stays open for 32 clocks, which is eight subcarrier cycles. Any malformed sync therefore suppresses the burst for that line. The first broad pulse after a run of equalizing pulses opens a vertical interval. Every second vertical interval, counted from reset, gives a one-cycle frame-start strobe. A single standard-select input picks the NTSC or the PAL set of window and burst constants.

Top module: `csync_separator`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it falls, `hsync_ok`, `frame_start` and `burst_gate` are 0. Reset also clears the vertical-interval parity, so the next vertical interval is the first one.
- R2: Width is the number of consecutive rising clock edges that sample `sync_n` low. A pulse whose width lies in the inclusive window of the selected standard (NTSC 56..72, PAL 69..89) is a line sync. `hsync_ok` is then high for exactly one cycle, beginning after the first edge that samples `sync_n` high again. That is `width` cycles after the first edge that sampled it low.
- R3: A pulse whose width is outside the window but not above twice the window maximum produces no `hsync_ok` and no burst, and is treated as an equalizing pulse.
- R4: After a qualified line sync, `burst_gate` rises a fixed number of cycles after the first edge that sampled the pulse low: 76 in NTSC, 97 in PAL.
- R5: An opened burst gate stays high for exactly 32 consecutive cycles.
- R6: A pulse wider than twice the window maximum (NTSC above 144, PAL above 178) is a broad pulse and produces neither `hsync_ok` nor a burst.
- R7: A vertical interval begins only at a broad pulse that is preceded by at least one equalizing pulse since the last line sync or the last interval start. Further broad pulses in the same interval, and broad pulses that directly follow a line sync, do not begin one.
- R8: `frame_start` is high for one cycle at the trailing edge of the broad pulse that opens the 2nd, 4th, 6th and later vertical intervals after reset. It never coincides with `hsync_ok`.
- R9: The width counter saturates at 2^CNT_W-1 (1023 by default). A low level held for any length is classified as a broad pulse when it is released and never as a line sync.
- R10: `std_ntsc` = 1 selects the NTSC constants and 0 selects the PAL constants. It must be held stable from a pulse's leading edge to the end of its burst. A width valid only in NTSC (such as 64) is rejected in PAL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at four times the subcarrier frequency |
| rst | input | 1 | Synchronous active-high reset |
| std_ntsc | input | 1 | 1 = NTSC timing constants, 0 = PAL |
| sync_n | input | 1 | Composite sync, active low, synchronous to clk |
| hsync_ok | output | 1 | One-cycle strobe at the trailing edge of a qualified line sync |
| frame_start | output | 1 | One-cycle strobe at the opening of every second vertical interval |
| burst_gate | output | 1 | High during the 32-cycle colour burst window |

## Verification
A wrong width count or window shows up on the first misjudged pulse. `hsync_ok` appears one cycle early or late, or is missing, at that pulse's trailing edge. The burst then moves or vanishes on the same line. A burst offset or length error is visible within about 110 cycles of the leading edge. A stuck equalizing-run flag or a wrong interval parity cannot be seen until the next vertical interval. There it shows only as a `frame_start` in the wrong interval, so the bench builds interval sequences that make a skipped or extra parity toggle change where the strobe lands.

// File: rtl/csync_sep_pkg.sv
package csync_sep_pkg;

   // Classification of a completed low pulse, valid in the trailing-edge cycle.
   typedef enum logic [1:0] {
      PK_NONE  = 2'd0,
      PK_HSYNC = 2'd1,
      PK_EQ    = 2'd2,
      PK_BROAD = 2'd3
   } pulse_kind_t;

endpackage

// File: rtl/csync_edge_meas.sv
// Edge detection on the sync input and a saturating low-time counter.
module csync_edge_meas #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sync_n,
   output logic             fall,
   output logic             rise,
   output logic [CNT_W-1:0] width
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             sync_q;
   logic [CNT_W-1:0] wcnt;

   always_ff @(posedge clk) begin
      if (rst) sync_q <= 1'b1;
      else     sync_q <= sync_n;
   end

   assign fall = sync_q & ~sync_n;
   assign rise = ~sync_q & sync_n;

   // Count low samples; hold at the ceiling so a stuck line never wraps.
   always_ff @(posedge clk) begin
      if (rst) begin
         wcnt <= '0;
      end else if (fall) begin
         wcnt <= CNT_W'(1);
      end else if (!sync_n && (wcnt != CNT_MAX)) begin
         wcnt <= wcnt + CNT_W'(1);
      end
   end

   assign width = wcnt;

endmodule

// File: rtl/csync_classifier.sv
// Sorts a finished pulse by its low time against per-standard limits.
module csync_classifier
   import csync_sep_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int NTSC_WMIN = 56,
   parameter int NTSC_WMAX = 72,
   parameter int PAL_WMIN  = 69,
   parameter int PAL_WMAX  = 89
) (
   input  logic             std_ntsc,
   input  logic             rise,
   input  logic [CNT_W-1:0] width,
   output pulse_kind_t      kind
);
   localparam int N_STD = 2;

   logic [N_STD-1:0] in_win;
   logic [N_STD-1:0] is_broad;

   // Index 1 = NTSC, index 0 = PAL.
   for (genvar gi = 0; gi < N_STD; gi++) begin : g_std
      localparam int LO = (gi == 1) ? NTSC_WMIN : PAL_WMIN;
      localparam int HI = (gi == 1) ? NTSC_WMAX : PAL_WMAX;
      localparam logic [CNT_W-1:0] LO_C    = CNT_W'(LO);
      localparam logic [CNT_W-1:0] HI_C    = CNT_W'(HI);
      localparam logic [CNT_W-1:0] BROAD_C = CNT_W'(2 * HI);
      assign in_win[gi]   = (width >= LO_C) && (width <= HI_C);
      assign is_broad[gi] = (width > BROAD_C);
   end

   logic sel_win;
   logic sel_broad;
   assign sel_win   = std_ntsc ? in_win[1]   : in_win[0];
   assign sel_broad = std_ntsc ? is_broad[1] : is_broad[0];

   always_comb begin
      if (!rise)          kind = PK_NONE;
      else if (sel_win)   kind = PK_HSYNC;
      else if (sel_broad) kind = PK_BROAD;
      else                kind = PK_EQ;
   end

endmodule

// File: rtl/csync_field_track.sv
// Tracks equalizing runs and vertical-interval parity; issues frame strobe.
module csync_field_track
   import csync_sep_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  pulse_kind_t kind,
   output logic        frame_stb
);
   logic eq_run;
   logic odd_seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         eq_run    <= 1'b0;
         odd_seen  <= 1'b0;
         frame_stb <= 1'b0;
      end else begin
         frame_stb <= 1'b0;
         case (kind)
            PK_EQ:    eq_run <= 1'b1;
            PK_HSYNC: eq_run <= 1'b0;
            PK_BROAD: begin
               if (eq_run) begin
                  odd_seen  <= ~odd_seen;
                  frame_stb <= odd_seen;
                  eq_run    <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/csync_burst_gate.sv
// Line strobe register, leading-edge phase counter and burst window.
module csync_burst_gate
   import csync_sep_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int NTSC_BOFS = 76,
   parameter int PAL_BOFS  = 97,
   parameter int BURST_LEN = 32
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        std_ntsc,
   input  logic        fall,
   input  pulse_kind_t kind,
   output logic        line_stb,
   output logic        burst
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] N_OFS   = CNT_W'(NTSC_BOFS);
   localparam logic [CNT_W-1:0] P_OFS   = CNT_W'(PAL_BOFS);
   localparam logic [CNT_W-1:0] LEN_C   = CNT_W'(BURST_LEN);

   logic [CNT_W-1:0] lcnt;
   logic             armed;
   logic [CNT_W-1:0] ofs;
   logic [CNT_W-1:0] ofs_end;

   always_ff @(posedge clk) begin
      if (rst) line_stb <= 1'b0;
      else     line_stb <= (kind == PK_HSYNC);
   end

   // Cycles since the last leading edge; idles saturated.
   always_ff @(posedge clk) begin
      if (rst)                  lcnt <= CNT_MAX;
      else if (fall)            lcnt <= '0;
      else if (lcnt != CNT_MAX) lcnt <= lcnt + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst || fall)            armed <= 1'b0;
      else if (kind == PK_HSYNC)  armed <= 1'b1;
   end

   assign ofs     = std_ntsc ? N_OFS : P_OFS;
   assign ofs_end = ofs + LEN_C;
   assign burst   = armed && (lcnt >= ofs) && (lcnt < ofs_end);

endmodule

// File: rtl/csync_separator.sv
module csync_separator
   import csync_sep_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int NTSC_WMIN = 56,
   parameter int NTSC_WMAX = 72,
   parameter int PAL_WMIN  = 69,
   parameter int PAL_WMAX  = 89,
   parameter int NTSC_BOFS = 76,
   parameter int PAL_BOFS  = 97,
   parameter int BURST_LEN = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic std_ntsc,
   input  logic sync_n,
   output logic hsync_ok,
   output logic frame_start,
   output logic burst_gate
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   initial begin : p_param_chk
      assert (NTSC_WMIN >= 1 && NTSC_WMIN <= NTSC_WMAX)
         else $error("NTSC window bounds inconsistent");
      assert (PAL_WMIN >= 1 && PAL_WMIN <= PAL_WMAX)
         else $error("PAL window bounds inconsistent");
      assert (NTSC_BOFS > NTSC_WMAX + 1 && PAL_BOFS > PAL_WMAX + 1)
         else $error("burst offset must follow the latest trailing edge");
      assert (CNT_MAX > 2 * NTSC_WMAX && CNT_MAX > 2 * PAL_WMAX)
         else $error("width counter too narrow for broad threshold");
      assert (CNT_MAX > NTSC_BOFS + BURST_LEN && CNT_MAX > PAL_BOFS + BURST_LEN)
         else $error("phase counter too narrow for burst window");
      assert (BURST_LEN >= 1)
         else $error("burst length must be positive");
   end

   logic             fall;
   logic             rise;
   logic [CNT_W-1:0] width;
   pulse_kind_t      kind;

   csync_edge_meas #(.CNT_W(CNT_W)) meas_i (
      .clk   (clk),
      .rst   (rst),
      .sync_n(sync_n),
      .fall  (fall),
      .rise  (rise),
      .width (width)
   );

   csync_classifier #(
      .CNT_W    (CNT_W),
      .NTSC_WMIN(NTSC_WMIN),
      .NTSC_WMAX(NTSC_WMAX),
      .PAL_WMIN (PAL_WMIN),
      .PAL_WMAX (PAL_WMAX)
   ) cls_i (
      .std_ntsc(std_ntsc),
      .rise    (rise),
      .width   (width),
      .kind    (kind)
   );

   csync_field_track fld_i (
      .clk      (clk),
      .rst      (rst),
      .kind     (kind),
      .frame_stb(frame_start)
   );

   csync_burst_gate #(
      .CNT_W    (CNT_W),
      .NTSC_BOFS(NTSC_BOFS),
      .PAL_BOFS (PAL_BOFS),
      .BURST_LEN(BURST_LEN)
   ) bg_i (
      .clk     (clk),
      .rst     (rst),
      .std_ntsc(std_ntsc),
      .fall    (fall),
      .kind    (kind),
      .line_stb(hsync_ok),
      .burst   (burst_gate)
   );

endmodule

// File: rtl/csync_sep_chk.sv
module csync_sep_chk #(
   parameter int BURST_LEN = 32
) (
   input logic clk,
   input logic rst,
   input logic sync_n,
   input logic hsync_ok,
   input logic frame_start,
   input logic burst_gate
);
   localparam int BW = $clog2(BURST_LEN + 2) + 1;

   logic          prev_n;
   logic          hseen;
   logic [BW-1:0] brun;

   always_ff @(posedge clk) begin
      if (rst) prev_n <= 1'b1;
      else     prev_n <= sync_n;
   end

   // Set by a line strobe, cleared by every new leading edge.
   always_ff @(posedge clk) begin
      if (rst)                    hseen <= 1'b0;
      else if (prev_n && !sync_n) hseen <= 1'b0;
      else if (hsync_ok)          hseen <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)             brun <= '0;
      else if (burst_gate) brun <= (brun == '1) ? brun : brun + BW'(1);
      else                 brun <= '0;
   end

   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!hsync_ok && !frame_start && !burst_gate));

   a_r2_hstrobe_single: assert property (@(posedge clk) disable iff (rst)
      hsync_ok |=> !hsync_ok);

   a_r2_hstrobe_at_trailing: assert property (@(posedge clk) disable iff (rst)
      hsync_ok |-> ($past(sync_n) && !$past(sync_n, 2)));

   a_r4_burst_needs_hsync: assert property (@(posedge clk) disable iff (rst)
      $rose(burst_gate) |-> hseen);

   a_r5_burst_bounded: assert property (@(posedge clk) disable iff (rst)
      brun <= BW'(BURST_LEN));

   a_r8_frame_single: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> !frame_start);

   a_r8_frame_not_hsync: assert property (@(posedge clk) disable iff (rst)
      !(frame_start && hsync_ok));

   a_r8_frame_at_trailing: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> ($past(sync_n) && !$past(sync_n, 2)));

endmodule

bind csync_separator csync_sep_chk #(.BURST_LEN(BURST_LEN)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .sync_n     (sync_n),
   .hsync_ok   (hsync_ok),
   .frame_start(frame_start),
   .burst_gate (burst_gate)
);

// File: tb/csync_separator_tb_top.sv
module csync_separator_tb_top;

   localparam int BLEN = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic std_ntsc = 1'b1;
   logic sync_n = 1'b1;
   logic hsync_ok, frame_start, burst_gate;

   always #10 clk = ~clk;

   csync_separator dut_i (
      .clk        (clk),
      .rst        (rst),
      .std_ntsc   (std_ntsc),
      .sync_n     (sync_n),
      .hsync_ok   (hsync_ok),
      .frame_start(frame_start),
      .burst_gate (burst_gate)
   );

   // Event kinds: 0 line strobe, 1 frame strobe, 2 burst opening
   typedef struct {
      int    kind;
      int    cycle;
      string req;
   } exp_t;

   exp_t  q[$];
   int    cyc = 0;
   int    checks = 0;
   int    fails = 0;
   int    seen = 0;
   int    blen = 0;
   bit    bprev = 1'b0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic pop_cmp(input int kind);
      exp_t e;
      if (q.size() == 0) begin
         chk(1'b0, "R3", $sformatf("unexpected event of kind %0d at cycle", kind), cyc, -1);
      end else begin
         e = q.pop_front();
         chk(e.kind == kind, e.req, "event kind", kind, e.kind);
         chk(e.cycle == cyc, e.req, $sformatf("cycle of event kind %0d", kind), cyc, e.cycle);
      end
   endtask

   // Monitor: compares observed events against the scoreboard queue.
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (hsync_ok) begin
            seen++;
            pop_cmp(0);
         end
         if (frame_start) begin
            seen++;
            pop_cmp(1);
         end
         if (burst_gate && !bprev) begin
            seen++;
            pop_cmp(2);
         end
         if (burst_gate) blen = bprev ? blen + 1 : 1;
         if (!burst_gate && bprev) chk(blen == BLEN, "R5", "burst length", blen, BLEN);
         bprev = burst_gate;
      end
   end

   // Driver: one low pulse; exp 1 = line sync, 2 = frame strobe, 0 = nothing.
   task automatic pulse(input int len, input int gap, input int exp, input string req);
      int   k;
      int   ofs;
      exp_t e;
      k   = cyc + 1;
      ofs = std_ntsc ? 76 : 97;
      if (exp == 1) begin
         e.kind = 0; e.cycle = k + len; e.req = req; q.push_back(e);
         e.kind = 2; e.cycle = k + ofs; e.req = "R4"; q.push_back(e);
      end else if (exp == 2) begin
         e.kind = 1; e.cycle = k + len; e.req = req; q.push_back(e);
      end
      sync_n = 1'b0;
      repeat (len) @(negedge clk);
      sync_n = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   task automatic reject(input int len, input int gap, input string req);
      int s;
      s = seen;
      pulse(len, gap, 0, req);
      chk(seen == s, req, $sformatf("events after rejected pulse of width %0d", len), seen - s, 0);
   endtask

   task automatic hline(input int len, input string req);
      pulse(len, 150, 1, req);
   endtask

   task automatic eqs(input int n);
      for (int i = 0; i < n; i++) reject(30, 40, "R3");
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired at cycle", cyc, 0);
      finish_run();
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      chk(hsync_ok == 1'b0, "R1", "hsync_ok in reset", hsync_ok, 0);
      chk(frame_start == 1'b0, "R1", "frame_start in reset", frame_start, 0);
      chk(burst_gate == 1'b0, "R1", "burst_gate in reset", burst_gate, 0);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      chk(hsync_ok == 1'b0 && burst_gate == 1'b0 && frame_start == 1'b0,
          "R1", "outputs after reset", {hsync_ok, frame_start, burst_gate}, 0);

      // R2 / R4 / R5: NTSC line syncs including window edges
      hline(64, "R2");
      hline(56, "R2");
      hline(72, "R2");
      reject(55, 150, "R3");
      reject(73, 150, "R3");
      reject(100, 150, "R3");
      reject(144, 150, "R3");
      hline(64, "R2");

      // R7 / R8: interval 1 opens silently, interval 2 strobes
      eqs(3);
      reject(200, 40, "R8");
      reject(200, 40, "R7");
      reject(200, 40, "R6");
      eqs(3);
      hline(64, "R2");
      eqs(3);
      pulse(200, 40, 2, "R8");
      reject(200, 40, "R7");
      eqs(3);
      hline(64, "R2");

      // R7: broad straight after a line sync opens nothing
      reject(200, 40, "R7");
      reject(200, 40, "R7");
      eqs(2);
      reject(200, 40, "R8");   // interval 3
      eqs(1);
      hline(64, "R2");
      eqs(2);
      pulse(200, 40, 2, "R7"); // interval 4
      eqs(1);
      hline(64, "R2");

      // R9: stuck-low line saturates and is judged broad
      reject(1100, 100, "R9");
      hline(64, "R9");

      // R10: PAL constants
      std_ntsc = 1'b0;
      repeat (5) @(negedge clk);
      hline(80, "R10");
      hline(69, "R10");
      hline(89, "R10");
      reject(68, 150, "R10");
      reject(90, 150, "R10");
      reject(64, 150, "R10");
      eqs(2);
      reject(160, 40, "R10");  // equalizing class in PAL
      reject(250, 40, "R8");   // interval 5
      eqs(2);
      hline(80, "R10");
      eqs(2);
      pulse(250, 40, 2, "R10"); // interval 6
      hline(80, "R10");

      repeat (20) @(negedge clk);
      chk(q.size() == 0, "R2", "expected events never seen", q.size(), 0);
      finish_run();
   end

endmodule